// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Logic Array

This block is a programmable AND/OR logic array. It has 16 logic inputs, 48 product terms and 8 outputs. Each product term is the AND of literals chosen from the inputs. Each input can enter a term in true form, in complemented form, or not at all. Each output ORs together any subset of the 48 terms. The output then passes through a programmable inversion stage.

The array is configured through a synchronous register-write port instead of fuse links. One product term, or one output's connection mask and polarity, is written per clock cycle. Evaluation from the inputs to the outputs is purely combinational and always uses the current register contents.

Each output is presented as a data bit plus an output-enable bit. An active-low chip enable can inhibit every output. A mode input selects how outputs are driven:

- In three-state mode, an inhibited output is not driven.
- In open-collector mode, an output is released (reads high) when it is inhibited or when its value is 1.

Top module: `pla_array`

## Requirements
- R1: After reset, every term literal pair is 2'b11, every OR mask is zero and every polarity bit is zero. With `ce_n`=0 and `oc_mode`=0, every input vector therefore gives `f_out`=0 and `f_oe`=8'hFF.
- R2: Term t holds 32 literal bits. Bit 2*i set requires input i to be 1. Bit 2*i+1 set requires input i to be 0. With both bits of a pair set, the term is 0 for every input vector. With neither bit set, input i is don't care. A term whose literals are all don't care evaluates to 1.
- R3: Bit t of output o's 48-bit mask connects term t to the OR sum of output o. The sum is 1 when any connected term is 1.
- R4: Output o's value is its OR sum XOR its polarity bit, where polarity 1 means inverted.
- R5: A write with `cfg_we`=1 and `cfg_kind`=0 loads `cfg_wdata[31:0]` into term `cfg_addr`. A write with `cfg_kind`=1 loads `cfg_wdata[47:0]` as the mask and `cfg_wdata[48]` as the polarity of output `cfg_addr`. Before the clock edge the outputs still reflect the old contents; after the edge they reflect the new contents.
- R6: A term write with `cfg_addr` of 48 or more, or an output write with `cfg_addr` of 8 or more, changes no configuration.
- R7: With `ce_n`=1, `f_oe` is all zeros. In open-collector mode (`oc_mode`=1), `f_out` is also all ones. In three-state mode, `f_out` carries the output values.
- R8: With `ce_n`=0 and `oc_mode`=0, `f_oe` is all ones and `f_out` equals the output values.
- R9: With `ce_n`=0 and `oc_mode`=1, `f_out` equals the output values and `f_oe` bit o is 1 only where output o's value is 0. Released bits therefore read as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset to the erased configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | Write target: 0 = product term, 1 = output mask and polarity |
| cfg_addr | input | 6 | Index of the term or output being written |
| cfg_wdata | input | 49 | Write data (term literals or polarity plus mask) |
| in_vec | input | 16 | Logic inputs to the array |
| ce_n | input | 1 | Active-low chip enable |
| oc_mode | input | 1 | Disabled-output behaviour: 0 = three-state, 1 = open-collector |
| f_out | output | 8 | Output data values |
| f_oe | output | 8 | Per-output drive enable |

## Verification
The assertions check the output stage on every cycle. They confirm that an inhibited array drives nothing and that open-collector mode reads high when inhibited. They also confirm that an enabled open-collector output is driven only while low, and that an enabled three-state array drives every output. Further properties check that out-of-range writes leave the outputs steady and that the erased state gives zero outputs right after reset. Only the bench scenarios can show that the literal encoding, the OR masks, the polarity bits and the write timing produce the correct Boolean function, because that requires a reference model of the programmed contents.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int N_IN   = 16;
    localparam int N_TERM = 48;
    localparam int N_OUT  = 8;
    localparam int LIT_W  = 2 * N_IN;
    localparam int ADDR_W = $clog2(N_TERM);
    localparam int CFG_W  = (LIT_W > N_TERM + 1) ? LIT_W : N_TERM + 1;

    typedef enum logic {
        CFG_TERM = 1'b0,
        CFG_OUT  = 1'b1
    } cfg_kind_e;

    typedef enum logic {
        MODE_TRI = 1'b0,
        MODE_OC  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT,
    parameter int ADDR_W = pla_pkg::ADDR_W,
    parameter int CFG_W  = pla_pkg::CFG_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  pla_pkg::cfg_kind_e                 kind,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [CFG_W-1:0]                   wdata,
    output logic [N_TERM-1:0][2*N_IN-1:0]      lits_o,
    output logic [N_OUT-1:0][N_TERM-1:0]       mask_o,
    output logic [N_OUT-1:0]                   pol_o
);
    localparam int LIT_W = 2 * N_IN;

    // Product-term literal registers; erased state forces every term to 0.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst) begin
                lits_o[t] <= '1;
            end else if (we && kind == pla_pkg::CFG_TERM && addr == ADDR_W'(t)) begin
                lits_o[t] <= wdata[LIT_W-1:0];
            end
        end
    end

    // Output OR masks and polarity bits; erased state connects nothing.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o[o] <= '0;
                pol_o[o]  <= 1'b0;
            end else if (we && kind == pla_pkg::CFG_OUT && addr == ADDR_W'(o)) begin
                mask_o[o] <= wdata[N_TERM-1:0];
                pol_o[o]  <= wdata[N_TERM];
            end
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = pla_pkg::N_IN,
    parameter int N_TERM = pla_pkg::N_TERM
) (
    input  logic [N_IN-1:0]                    x,
    input  logic [N_TERM-1:0][2*N_IN-1:0]      lits,
    output logic [N_TERM-1:0]                  term_o
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // true-form bit needs x=1, complement bit needs x=0
            assign lit_ok[i] = ~(lits[t][2*i] & ~x[i]) & ~(lits[t][2*i+1] & x[i]);
        end
        assign term_o[t] = &lit_ok;
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = pla_pkg::N_TERM,
    parameter int N_OUT  = pla_pkg::N_OUT
) (
    input  logic [N_TERM-1:0]                  terms,
    input  logic [N_OUT-1:0][N_TERM-1:0]       mask,
    input  logic [N_OUT-1:0]                   pol,
    output logic [N_OUT-1:0]                   val_o
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic sum;
        assign sum      = |(terms & mask[o]);
        assign val_o[o] = sum ^ pol[o];
    end
endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
    parameter int N_OUT = pla_pkg::N_OUT
) (
    input  logic [N_OUT-1:0]   val,
    input  logic               ce_n,
    input  pla_pkg::out_mode_e mode,
    output logic [N_OUT-1:0]   dout,
    output logic [N_OUT-1:0]   oe
);
    always_comb begin
        dout = val;
        oe   = '0;
        unique case (mode)
            pla_pkg::MODE_TRI: begin
                if (!ce_n) oe = '1;
            end
            pla_pkg::MODE_OC: begin
                if (ce_n) begin
                    dout = '1;
                end else begin
                    oe = ~val;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pla_array.sv
module pla_array (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic                          cfg_kind,
    input  logic [pla_pkg::ADDR_W-1:0]    cfg_addr,
    input  logic [pla_pkg::CFG_W-1:0]     cfg_wdata,
    input  logic [pla_pkg::N_IN-1:0]      in_vec,
    input  logic                          ce_n,
    input  logic                          oc_mode,
    output logic [pla_pkg::N_OUT-1:0]     f_out,
    output logic [pla_pkg::N_OUT-1:0]     f_oe
);
    import pla_pkg::*;

    logic [N_TERM-1:0][LIT_W-1:0]  lits;
    logic [N_OUT-1:0][N_TERM-1:0]  mask;
    logic [N_OUT-1:0]              pol;
    logic [N_TERM-1:0]             terms;
    logic [N_OUT-1:0]              val;
    cfg_kind_e                     kind;
    out_mode_e                     mode;

    assign kind = cfg_kind_e'(cfg_kind);
    assign mode = out_mode_e'(oc_mode);

    pla_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .kind(kind), .addr(cfg_addr),
        .wdata(cfg_wdata), .lits_o(lits), .mask_o(mask), .pol_o(pol)
    );

    pla_and_plane u_and (.x(in_vec), .lits(lits), .term_o(terms));

    pla_or_plane u_or (.terms(terms), .mask(mask), .pol(pol), .val_o(val));

    pla_out_stage u_out (.val(val), .ce_n(ce_n), .mode(mode), .dout(f_out), .oe(f_oe));
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk (
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_we,
    input logic                          cfg_kind,
    input logic [pla_pkg::ADDR_W-1:0]    cfg_addr,
    input logic [pla_pkg::N_IN-1:0]      in_vec,
    input logic                          ce_n,
    input logic                          oc_mode,
    input logic [pla_pkg::N_OUT-1:0]     f_out,
    input logic [pla_pkg::N_OUT-1:0]     f_oe
);
    import pla_pkg::*;

    logic bad_write;
    assign bad_write = cfg_we &&
        ((cfg_kind == 1'b0 && int'(cfg_addr) >= N_TERM) ||
         (cfg_kind == 1'b1 && int'(cfg_addr) >= N_OUT));

    a_r7_inhibit_no_drive: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> f_oe == '0);

    a_r7_oc_inhibit_high: assert property (@(posedge clk) disable iff (rst)
        (ce_n && oc_mode) |-> f_out == '1);

    a_r8_tri_all_driven: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oc_mode) |-> f_oe == '1);

    a_r9_oc_drive_low_only: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oc_mode) |-> ((f_oe & f_out) == '0 && (f_oe | f_out) == '1));

    a_r6_bad_addr_no_effect: assert property (@(posedge clk) disable iff (rst)
        bad_write |=> (!($stable(in_vec) && $stable(ce_n) && $stable(oc_mode)) || $stable(f_out)));

    a_r1_erased_zero: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !ce_n && !oc_mode) |-> f_out == '0);
endmodule

bind pla_array pla_array_chk u_chk (.*);

// File: tb/tb_pla_array.sv
module tb_pla_array;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 16, NT = 48, NO = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_kind = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [48:0] cfg_wdata = '0;
    logic [15:0] in_vec = '0;
    logic        ce_n = 1'b0;
    logic        oc_mode = 1'b0;
    logic [7:0]  f_out, f_oe;

    int total = 0, bad = 0;

    logic [31:0] m_lit [NT];
    logic [47:0] m_mask [NO];
    logic        m_pol [NO];

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_array dut (.*);

    function automatic logic [7:0] ref_val(logic [15:0] x);
        logic [47:0] tv;
        logic [7:0]  r;
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (m_lit[t][2*i] && x[i] == 1'b0) tv[t] = 1'b0;
                if (m_lit[t][2*i+1] && x[i] == 1'b1) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < NO; o++) r[o] = ((tv & m_mask[o]) != 0) ^ m_pol[o];
        return r;
    endfunction

    task automatic check(input string tag);
        logic [7:0] v, eo, ee;
        v = ref_val(in_vec);
        if (ce_n) begin
            ee = 8'h00; eo = oc_mode ? 8'hFF : v;
        end else if (oc_mode) begin
            ee = ~v; eo = v;
        end else begin
            ee = 8'hFF; eo = v;
        end
        total++;
        if (f_out !== eo || f_oe !== ee) begin
            bad++;
            $display("FAIL %s: in=%h ce_n=%b oc=%b out=%h/%h exp out=%h/%h",
                     tag, in_vec, ce_n, oc_mode, f_out, f_oe, eo, ee);
        end
    endtask

    task automatic apply(input logic [15:0] x, input logic c, input logic m, input string tag);
        @(negedge clk);
        in_vec = x; ce_n = c; oc_mode = m;
        #1 check(tag);
    endtask

    task automatic wr(input logic kind, input logic [5:0] a, input logic [48:0] d, input bit pre_chk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_addr = a; cfg_wdata = d;
        if (pre_chk) #1 check("R5 before edge");
        @(posedge clk);
        if (kind == 1'b0 && a < NT) m_lit[a] = d[31:0];
        if (kind == 1'b1 && a < NO) begin m_mask[a] = d[47:0]; m_pol[a] = d[48]; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] rand_term();
        logic [31:0] l = '0;
        for (int i = 0; i < NI; i++) begin
            int r = $urandom % 8;
            if (r == 6) l[2*i] = 1'b1;
            else if (r == 7) l[2*i+1] = 1'b1;
        end
        return l;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: expired, exp finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) m_lit[t] = '1;
        for (int o = 0; o < NO; o++) begin m_mask[o] = '0; m_pol[o] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: erased array
        apply(16'h0000, 1'b0, 1'b0, "R1 erased");
        apply(16'hFFFF, 1'b0, 1'b0, "R1 erased");
        apply(16'hA5C3, 1'b0, 1'b0, "R1 erased");

        // R2: all don't care term -> 1; forced-zero term; literal mix
        wr(1'b0, 6'd0, 49'd0, 1'b0);
        wr(1'b1, 6'd0, 49'h1, 1'b1);          // R5: pre-edge output still old
        apply(16'h1234, 1'b0, 1'b0, "R2 dont care term");
        wr(1'b0, 6'd1, 49'h0C0, 1'b0);        // input 3 both bits set
        wr(1'b1, 6'd3, 49'h2, 1'b0);
        wr(1'b0, 6'd2, 49'h9, 1'b0);          // in0 true, in1 complement
        wr(1'b1, 6'd4, 49'h4, 1'b0);
        wr(1'b1, 6'd5, 49'h6, 1'b0);          // R3: terms 1 and 2
        for (int x = 0; x < 16; x++) apply(16'(x), 1'b0, 1'b0, "R2 R3 sweep");

        // R4: polarity
        wr(1'b1, 6'd1, {1'b1, 48'h1}, 1'b0);
        wr(1'b1, 6'd2, {1'b1, 48'h0}, 1'b0);
        apply(16'h0001, 1'b0, 1'b0, "R4 polarity");

        // R7 R8 R9 on fixed config
        for (int k = 0; k < 4; k++) apply(16'h0001, k[0], k[1], "R7 R8 R9 modes");

        // Random full programming
        for (int t = 0; t < NT; t++) wr(1'b0, 6'(t), {17'd0, rand_term()}, 1'b0);
        for (int o = 0; o < NO; o++)
            wr(1'b1, 6'(o), {1'($urandom), 16'($urandom), 32'($urandom)}, 1'b0);
        for (int n = 0; n < 400; n++)
            apply(16'($urandom), n[0], n[1], "R3 R7 R8 R9 random");

        // R5: term rewrite observed before and after edge
        in_vec = 16'h0000; ce_n = 1'b0; oc_mode = 1'b0;
        wr(1'b0, 6'd0, 49'd0, 1'b1);
        wr(1'b1, 6'd7, 49'h1, 1'b1);
        apply(16'h0000, 1'b0, 1'b0, "R5 after edge");

        // R6: out-of-range writes
        wr(1'b0, 6'd48, 49'd0, 1'b0);
        wr(1'b0, 6'd63, 49'd0, 1'b0);
        wr(1'b1, 6'd8, 49'h1_FFFF_FFFF_FFFF, 1'b0);
        wr(1'b1, 6'd40, 49'h1_FFFF_FFFF_FFFF, 1'b0);
        for (int n = 0; n < 50; n++) apply(16'($urandom), 1'b0, n[0], "R6 ignored write");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule